// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This unit multiplies two 32-bit operands and places the 64-bit outcome in a pair of 32-bit result registers. HI holds the upper word and LO holds the lower word. Beyond a plain product, it can add the product to the value already held in HI:LO or subtract it from that value. Each of the three forms comes in a signed variant and an unsigned variant. Software can also load HI and LO directly through two independent write ports, for example to seed an accumulation or to restore saved state.

An operation starts with a one-cycle `start` strobe that carries the operand pair and a 3-bit operation code. The datapath is single-cycle. At the next rising clock edge HI and LO hold the new value and `done` is high for exactly one cycle. Accumulation wraps modulo 2^64 and raises no overflow indication.

Top module: `hilo_mac`

## Requirements
- R1: While reset is asserted, and after it is released, HI and LO read zero and `done` is low until the first `start`.
- R2: HI receives bits 63:32 of the 64-bit result and LO receives bits 31:0.
- R3: Operation code 000 (signed multiply) sign-extends both operands to 64 bits and writes their product to HI:LO.
- R4: Operation code 001 (unsigned multiply) zero-extends both operands to 64 bits and writes their product to HI:LO.
- R5: Operation code 010 (signed multiply-add) adds the signed 64-bit product to the current HI:LO and writes back the sum.
- R6: Operation code 011 (unsigned multiply-add) adds the unsigned 64-bit product to the current HI:LO and writes back the sum.
- R7: Operation codes 100 (signed) and 101 (unsigned) subtract the product from the current HI:LO and write back the difference.
- R8: Accumulation and subtraction wrap modulo 2^64, with no overflow or borrow output.
- R9: A `start` with operation code 110 or 111 leaves HI and LO unchanged.
- R10: `done` is high in exactly the cycle after each `start` (whatever its code) and low in every other cycle.
- R11: `hi_we` loads `hi_wdata` into HI, and `lo_we` loads `lo_wdata` into LO, at the next edge. Each port is independent of the other.
- R12: If a direct write and a valid operation (codes 000 to 101) fall in the same cycle, the operation result is stored and the direct write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe that launches an operation |
| op | input | 3 | Operation code, sampled with `start` |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| hi_we | input | 1 | Direct write enable for HI |
| hi_wdata | input | 32 | Direct write data for HI |
| lo_we | input | 1 | Direct write enable for LO |
| lo_wdata | input | 32 | Direct write data for LO |
| hi | output | 32 | Upper result word |
| lo | output | 32 | Lower result word |
| done | output | 1 | High for one cycle after `start` |

## Verification
An operation that completes and a direct software write to HI or LO can land in the same clock cycle. The bench provokes this by raising `start` with a valid code together with `hi_we` and `lo_we`, using write data that differs from the product. It then judges the next cycle's HI and LO against the product computed by its own model, which must win over the written data. A second case pairs a direct write with an invalid code; there the write must take effect, since nothing completes.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  // Arithmetic form selected by the upper two opcode bits
  typedef enum logic [1:0] {
    FORM_PLAIN = 2'b00,
    FORM_ADD   = 2'b01,
    FORM_SUB   = 2'b10,
    FORM_NONE  = 2'b11
  } form_t;

  localparam int OP_W = 3;

  function automatic form_t op_form(input logic [OP_W-1:0] code);
    return form_t'(code[OP_W-1:1]);
  endfunction

  function automatic logic op_unsigned(input logic [OP_W-1:0] code);
    return code[0];
  endfunction

  function automatic logic op_valid(input logic [OP_W-1:0] code);
    return op_form(code) != FORM_NONE;
  endfunction

endpackage

// File: rtl/hilo_mul.sv
module hilo_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           uns,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  // Widen an operand to the product width, by sign or by zeros
  function automatic logic [PW-1:0] widen(input logic [W-1:0] x, input logic zero_ext);
    logic fill;
    fill = zero_ext ? 1'b0 : x[W-1];
    return {{W{fill}}, x};
  endfunction

  logic [PW-1:0] a_wide;
  logic [PW-1:0] b_wide;

  assign a_wide = widen(a, uns);
  assign b_wide = widen(b, uns);
  // Low PW bits of the widened product are exact for both signednesses
  assign prod   = a_wide * b_wide;

endmodule

// File: rtl/hilo_acc.sv
module hilo_acc #(
  parameter int W = 32
) (
  input  logic [2*W-1:0]      acc,
  input  logic [2*W-1:0]      prod,
  input  hilo_pkg::form_t     form,
  output logic [2*W-1:0]      next_val
);
  import hilo_pkg::*;
  localparam int PW = 2 * W;

  // Combine product with the held value; wraps modulo 2^PW
  function automatic logic [PW-1:0] combine(input logic [PW-1:0] held,
                                            input logic [PW-1:0] p,
                                            input form_t f);
    case (f)
      FORM_PLAIN: return p;
      FORM_ADD:   return held + p;
      FORM_SUB:   return held - p;
      default:    return held;
    endcase
  endfunction

  assign next_val = combine(acc, prod, form);

  // R9
  always_comb begin
    if (form == FORM_NONE) begin
      hold_on_bad_form_chk: assert (next_val == acc);
    end
  end

endmodule

// File: rtl/hilo_regs.sv
module hilo_regs #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit,
  input  logic [2*W-1:0] result,
  input  logic           hi_we,
  input  logic [W-1:0]   hi_wdata,
  input  logic           lo_we,
  input  logic [W-1:0]   lo_wdata,
  output logic [W-1:0]   hi_q,
  output logic [W-1:0]   lo_q
);
  localparam int NHALF = 2;

  logic [W-1:0] half_q  [NHALF];
  logic         wr_en   [NHALF];
  logic [W-1:0] wr_data [NHALF];

  // Index 0 is LO (result bits W-1:0), index 1 is HI
  assign wr_en[0]   = lo_we;
  assign wr_en[1]   = hi_we;
  assign wr_data[0] = lo_wdata;
  assign wr_data[1] = hi_wdata;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          half_q[h] <= '0;
      else if (commit)     half_q[h] <= result[h*W +: W];
      else if (wr_en[h])   half_q[h] <= wr_data[h];
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) !rst_n |-> half_q[h] == '0);

    // R12
    op_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && wr_en[h]) |=> half_q[h] == $past(result[h*W +: W]));

    // R11
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[h] && !commit) |=> half_q[h] == $past(wr_data[h]));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en[h] && !commit) |=> $stable(half_q[h]));
  end

  assign lo_q = half_q[0];
  assign hi_q = half_q[1];

endmodule

// File: rtl/hilo_mac.sv
module hilo_mac #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         hi_we,
  input  logic [W-1:0] hi_wdata,
  input  logic         lo_we,
  input  logic [W-1:0] lo_wdata,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo,
  output logic         done
);
  import hilo_pkg::*;
  localparam int PW = 2 * W;

  // Named internal events
  logic          op_commit;
  logic          op_uns;
  form_t         op_kind;
  logic [PW-1:0] product;
  logic [PW-1:0] held;
  logic [PW-1:0] next_val;

  assign op_kind   = op_form(op);
  assign op_uns    = op_unsigned(op);
  assign op_commit = start && op_valid(op);
  assign held      = {hi, lo};

  hilo_mul #(.W(W)) u_mul (
    .a    (opa),
    .b    (opb),
    .uns  (op_uns),
    .prod (product)
  );

  hilo_acc #(.W(W)) u_acc (
    .acc      (held),
    .prod     (product),
    .form     (op_kind),
    .next_val (next_val)
  );

  hilo_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (op_commit),
    .result   (next_val),
    .hi_we    (hi_we),
    .hi_wdata (hi_wdata),
    .lo_we    (lo_we),
    .lo_wdata (lo_wdata),
    .hi_q     (hi),
    .lo_q     (lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= start;
  end

  // R10
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  // R9
  bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !op_valid(op) && !hi_we && !lo_we) |=> ($stable(hi) && $stable(lo)));

  // R1
  reset_done_low_chk: assert property (@(posedge clk) !rst_n |-> !done);

endmodule

// File: tb/test_hilo_mac.sv
module test_hilo_mac;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = 3'b000;
  logic [31:0] opa = '0, opb = '0;
  logic        hi_we = 1'b0, lo_we = 1'b0;
  logic [31:0] hi_wdata = '0, lo_wdata = '0;
  logic [31:0] hi, lo;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hilo_mac i_hilo_mac (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata),
    .hi(hi), .lo(lo), .done(done)
  );

  // Vector table: code, a, b, preloaded HI, preloaded LO, requirement number
  localparam int NV = 10;
  localparam logic [2:0]  V_OP [NV] = '{3'd0, 3'd1, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd3, 3'd2};
  localparam logic [31:0] V_A  [NV] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h80000000, 32'hFFFFFFFF,
                                       32'hFFFFFFFE, 32'hFFFFFFFE, 32'hFFFFFFFE, 32'h2,
                                       32'h1, 32'h7FFFFFFF};
  localparam logic [31:0] V_B  [NV] = '{32'h3, 32'h3, 32'h80000000, 32'hFFFFFFFF,
                                       32'h5, 32'h5, 32'h5, 32'h3, 32'h1, 32'h7FFFFFFF};
  localparam logic [31:0] V_HI [NV] = '{32'h1234, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                                       32'h0, 32'hFFFFFFFF, 32'h7FFFFFFF};
  localparam logic [31:0] V_LO [NV] = '{32'h5678, 32'h0, 32'h0, 32'h0, 32'h64, 32'h64, 32'h64,
                                       32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF};
  // R3 R4 R3 R2/R4 R5 R6 R7 R7/R8 R8 R8
  localparam int          V_REQ[NV] = '{3, 4, 3, 2, 5, 6, 7, 7, 8, 8};

  // Independent model: 64-bit integer arithmetic on extended operands
  function automatic logic [63:0] model(input logic [2:0] code, input logic [31:0] a,
                                        input logic [31:0] b, input logic [63:0] acc);
    longint x, y, p;
    if (code[0]) begin
      x = longint'({32'd0, a});
      y = longint'({32'd0, b});
    end else begin
      x = longint'($signed(a));
      y = longint'($signed(b));
    end
    p = x * y;
    case (code)
      3'd0, 3'd1: return 64'(p);
      3'd2, 3'd3: return acc + 64'(p);
      3'd4, 3'd5: return acc - 64'(p);
      default:    return acc;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [31:0] h, input logic [31:0] l);
    @(negedge clk);
    hi_we = 1'b1; hi_wdata = h; lo_we = 1'b1; lo_wdata = l;
    @(negedge clk);
    hi_we = 1'b0; lo_we = 1'b0;
  endtask

  task automatic run(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; op = code; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    logic [63:0] expv;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: values during reset
    check("R1", "hilo in reset", {hi, lo}, 64'd0);
    check("R1", "done in reset", {63'd0, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "hilo after reset", {hi, lo}, 64'd0);
    check("R1", "done after reset", {63'd0, done}, 64'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      load(V_HI[i], V_LO[i]);
      expv = model(V_OP[i], V_A[i], V_B[i], {V_HI[i], V_LO[i]});
      run(V_OP[i], V_A[i], V_B[i]);
      check($sformatf("R%0d", V_REQ[i]), $sformatf("vector %0d HI", i), {32'd0, hi}, {32'd0, expv[63:32]});
      check($sformatf("R%0d", V_REQ[i]), $sformatf("vector %0d LO", i), {32'd0, lo}, {32'd0, expv[31:0]});
      check("R10", $sformatf("done after vector %0d", i), {63'd0, done}, 64'd1);
    end
    // R10: one-cycle pulse
    @(negedge clk);
    check("R10", "done falls", {63'd0, done}, 64'd0);

    // R9: invalid codes hold, yet still pulse done
    load(32'hCAFEF00D, 32'h0BADBEEF);
    run(3'b110, 32'h10, 32'h20);
    check("R9", "code 110 keeps hilo", {hi, lo}, 64'hCAFEF00D_0BADBEEF);
    check("R10", "done on code 110", {63'd0, done}, 64'd1);
    run(3'b111, 32'hFFFFFFFF, 32'h2);
    check("R9", "code 111 keeps hilo", {hi, lo}, 64'hCAFEF00D_0BADBEEF);

    // R11: independent direct writes
    @(negedge clk);
    hi_we = 1'b1; hi_wdata = 32'hA5A5A5A5;
    @(negedge clk);
    hi_we = 1'b0;
    check("R11", "HI-only write", {hi, lo}, 64'hA5A5A5A5_0BADBEEF);
    lo_we = 1'b1; lo_wdata = 32'h5A5A5A5A;
    @(negedge clk);
    lo_we = 1'b0;
    check("R11", "LO-only write", {hi, lo}, 64'hA5A5A5A5_5A5A5A5A);

    // R12: operation and direct write in the same cycle
    @(negedge clk);
    start = 1'b1; op = 3'b010; opa = 32'h3; opb = 32'h4;
    hi_we = 1'b1; hi_wdata = 32'h11111111; lo_we = 1'b1; lo_wdata = 32'h22222222;
    expv = model(3'b010, 32'h3, 32'h4, 64'hA5A5A5A5_5A5A5A5A);
    @(negedge clk);
    start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    check("R12", "operation wins collision", {hi, lo}, expv);

    // R12 counterpart: invalid code does not block the write
    @(negedge clk);
    start = 1'b1; op = 3'b111; hi_we = 1'b1; hi_wdata = 32'h33333333;
    @(negedge clk);
    start = 1'b0; hi_we = 1'b0;
    check("R12", "write lands with invalid code", {32'd0, hi}, 64'h33333333);

    finished = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule